// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block is a per-core hardware watchdog. Software programs a 16-bit length and a 2-bit escalation mode through a control write. It must then service the block with a poke strobe before each programmed period runs out. A prescaler divides the clock by a fixed power-of-two divisor. Each prescaler tick decrements a 24-bit down-counter. The 16-bit length supplies the top bits of that counter, and its low 8 bits reload as zero.

Each time a period expires without service, the watchdog climbs one stage. The first expiry raises the interrupt. The second raises the non-maskable interrupt. The third issues a one-cycle soft-reset request. The mode value caps how far the escalation may climb. A poke or a new control write reloads the counter, restarts the prescaler and returns the block to the idle stage. The live counter value is always visible, so software can see how much of the current period remains.

Top module: `staged_wdog`

## Requirements
- R1: After synchronous reset, irq_o, nmi_o and rst_req_o are low, the count is 0, and the block is disabled (mode 0).
- R2: A control write (cfg_we high at a clock edge) takes cfg_len and cfg_mode. After that edge the count reads {cfg_len, 8'h00}, the stage is idle, and the prescaler restarts from zero.
- R3: While enabled, the count decreases by exactly one at the end of every DIVISOR clock cycles, counted from the last control write or poke. DIVISOR is a parameter limited to 256, 512 or 1024.
- R4: A period lasts LEN×256 ticks. At its last tick (count 1) the count reloads to {LEN, 8'h00} instead of reaching zero. LEN = 0 gives a one-tick period, and the count then stays 0.
- R5: The mode encoding is 0 = disabled, 1 = interrupt only, 2 = interrupt then NMI, 3 = interrupt, NMI, then reset. Stages above the selected mode are never entered, and further expiries leave the top allowed stage in place.
- R6: irq_o rises at the first unserviced expiry and nmi_o at the second. Both are levels that hold until a poke or a control write.
- R7: In mode 3, the third unserviced expiry drives rst_req_o high for exactly one cycle. It does not pulse again until the stage is cleared.
- R8: A poke (poke high at a clock edge) reloads the count to {LEN, 8'h00}, clears irq_o and nmi_o after that edge, and restarts the prescaler. A control write in the same cycle takes priority.
- R9: With mode 0 the count holds its value, no output ever asserts, and pokes produce no output activity.
- R10: nmi_o is never high while irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_len | input | 16 | Period length (upper counter bits) |
| cfg_mode | input | 2 | Escalation mode |
| poke | input | 1 | Service strobe |
| cnt_value | output | 24 | Current down-counter value |
| irq_o | output | 1 | First-stage interrupt level |
| nmi_o | output | 1 | Second-stage non-maskable interrupt level |
| rst_req_o | output | 1 | Third-stage soft-reset request pulse |

## Verification
The assertions check the following on every cycle:
- the nesting of the NMI level under the interrupt level;
- the single-cycle reset request, which appears only in mode 3 and only with both lower stages up;
- the clearing effect of a poke or write;
- the bound of the count by the programmed length;
- the frozen count and silent outputs while disabled.

Some behaviour can only be shown by the bench's timed scenarios, which compare every cycle against an elapsed-time formula:
- the exact tick cadence of the prescaler;
- the period length of LEN×256 ticks and the reload;
- the cycle at which each stage arrives;
- the way a poke at an arbitrary moment restarts all of the timing.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int LEN_W = 16;
    localparam int LOW_W = 8;
    localparam int CNT_W = LEN_W + LOW_W;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_IRQ     = 2'd1,
        MODE_IRQ_NMI = 2'd2,
        MODE_FULL    = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IRQ  = 2'd1,
        ST_NMI  = 2'd2,
        ST_RST  = 2'd3
    } stage_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        mode_e            mode;
    } ctrl_t;

    // Stage numbering matches mode numbering: a stage may be entered
    // only while its index does not exceed the mode value.
    function automatic stage_e step_stage(stage_e cur, mode_e m);
        logic [1:0] c;
        logic [1:0] lim;
        c   = cur;
        lim = m;
        if (c < lim)
            return stage_e'(c + 2'd1);
        return cur;
    endfunction

    function automatic logic [CNT_W-1:0] period_load(logic [LEN_W-1:0] l);
        return {l, {LOW_W{1'b0}}};
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIVISOR = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int PRE_W = $clog2(DIVISOR);
    localparam logic [PRE_W-1:0] LAST = PRE_W'(DIVISOR - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            pre_q <= '0;
        else if (pre_q == LAST)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    assign tick = run && !restart && (pre_q == LAST);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_src,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             last_tick;

    assign last_tick = (cnt_q <= CNT_W'(1));
    assign expire    = tick && !load && last_tick;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= period_load(len_src);
        else if (tick) begin
            if (last_tick)
                cnt_q <= period_load(len_src);
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
    import wdog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   expire,
    input  mode_e  mode,
    output stage_e stage,
    output logic   rst_pulse
);
    stage_e stage_q;
    stage_e stage_nx;
    logic   pulse_q;

    assign stage_nx = step_stage(stage_q, mode);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            stage_q <= ST_IDLE;
            pulse_q <= 1'b0;
        end else if (expire) begin
            stage_q <= stage_nx;
            pulse_q <= (stage_nx == ST_RST) && (stage_q != ST_RST);
        end else begin
            pulse_q <= 1'b0;
        end
    end

    assign stage     = stage_q;
    assign rst_pulse = pulse_q;

endmodule

// File: rtl/staged_wdog.sv
module staged_wdog
    import wdog_pkg::*;
#(
    parameter int DIVISOR = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [15:0]      cfg_len,
    input  logic [1:0]       cfg_mode,
    input  logic             poke,
    output logic [23:0]      cnt_value,
    output logic             irq_o,
    output logic             nmi_o,
    output logic             rst_req_o
);
    ctrl_t            ctrl_q;
    logic             enabled;
    logic             restart;
    logic             tick;
    logic             expire;
    logic [LEN_W-1:0] len_src;
    stage_e           stage;
    logic             rst_pulse;
    logic [1:0]       mode_now;
    logic [LEN_W-1:0] len_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.len  <= '0;
            ctrl_q.mode <= MODE_OFF;
        end else if (cfg_we) begin
            ctrl_q.len  <= cfg_len;
            ctrl_q.mode <= mode_e'(cfg_mode);
        end
    end

    assign enabled  = (ctrl_q.mode != MODE_OFF);
    assign restart  = cfg_we || poke;
    assign len_src  = cfg_we ? cfg_len : ctrl_q.len;
    assign mode_now = ctrl_q.mode;
    assign len_now  = ctrl_q.len;

    wdog_prescaler #(.DIVISOR(DIVISOR)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (enabled),
        .tick    (tick)
    );

    wdog_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (restart),
        .len_src (len_src),
        .tick    (tick),
        .count   (cnt_value),
        .expire  (expire)
    );

    wdog_stage u_stg (
        .clk       (clk),
        .rst       (rst),
        .clear     (restart),
        .expire    (expire),
        .mode      (ctrl_q.mode),
        .stage     (stage),
        .rst_pulse (rst_pulse)
    );

    assign irq_o     = (stage != ST_IDLE);
    assign nmi_o     = (stage == ST_NMI) || (stage == ST_RST);
    assign rst_req_o = rst_pulse;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic        poke,
    input logic [1:0]  mode,
    input logic [15:0] len,
    input logic [23:0] cnt,
    input logic        irq,
    input logic        nmi,
    input logic        rstq
);
    // R10
    nmi_nested_chk: assert property (@(posedge clk) disable iff (rst)
        nmi |-> irq);

    // R7
    rst_single_chk: assert property (@(posedge clk) disable iff (rst)
        rstq |=> !rstq);

    // R7
    rst_full_mode_chk: assert property (@(posedge clk) disable iff (rst)
        rstq |-> (mode == 2'd3) && irq && nmi);

    // R8
    service_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (poke || cfg_we) |=> !irq && !nmi && !rstq);

    // R9
    off_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |-> !irq && !nmi && !rstq);

    // R9
    off_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && !cfg_we && !poke) |=> $stable(cnt));

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= {len, 8'h00});

    // R5
    irq_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi) |-> mode >= 2'd2);

endmodule

bind staged_wdog wdog_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cfg_we (cfg_we),
    .poke   (poke),
    .mode   (mode_now),
    .len    (len_now),
    .cnt    (cnt_value),
    .irq    (irq_o),
    .nmi    (nmi_o),
    .rstq   (rst_req_o)
);

// File: tb/staged_wdog_test.sv
`timescale 1ns/1ps
module staged_wdog_test;
    localparam int D = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_len = '0;
    logic [1:0]  cfg_mode = '0;
    logic        poke = 1'b0;
    logic [23:0] cnt_value;
    logic        irq_o, nmi_o, rst_req_o;

    int chk = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    staged_wdog #(.DIVISOR(D)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_len(cfg_len),
        .cfg_mode(cfg_mode), .poke(poke), .cnt_value(cnt_value),
        .irq_o(irq_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
    );

    task automatic check(input bit ok, input string tag,
                         input longint act, input longint exp);
        chk++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint exp_ticks(int n, int m);
        return (m == 0) ? 0 : longint'(n / D);
    endfunction

    function automatic longint period_ticks(int l);
        return (l == 0) ? 1 : longint'(l) * 256;
    endfunction

    function automatic longint exp_count(int n, int l, int m);
        if (l == 0) return 0;
        return longint'(l) * 256 - (exp_ticks(n, m) % period_ticks(l));
    endfunction

    function automatic int exp_stage(int n, int l, int m);
        longint s;
        s = exp_ticks(n, m) / period_ticks(l);
        return (s > m) ? m : int'(s);
    endfunction

    function automatic bit exp_rst(int n, int l, int m);
        return (m == 3) && (n % D == 0) && (exp_ticks(n, m) == 3 * period_ticks(l));
    endfunction

    task automatic compare(int n, int l, int m, string tag);
        int st;
        st = exp_stage(n, l, m);
        check(cnt_value == 24'(exp_count(n, l, m)),
              (n == 0) ? {tag, " R2 count"} : {tag, " R3 R4 count"},
              cnt_value, exp_count(n, l, m));
        check(irq_o == (st >= 1), {tag, " R5 R6 irq"}, irq_o, st >= 1);
        check(nmi_o == (st >= 2), {tag, " R5 R6 nmi"}, nmi_o, st >= 2);
        check(rst_req_o == exp_rst(n, l, m), {tag, " R7 rst_req"},
              rst_req_o, exp_rst(n, l, m));
        check(!(nmi_o && !irq_o), {tag, " R10 nesting"}, nmi_o, irq_o);
    endtask

    task automatic run_scn(input int l, input int m, input int cycles,
                           input int poke_at, input string tag);
        int n;
        @(negedge clk);
        cfg_len  = 16'(l);
        cfg_mode = 2'(m);
        cfg_we   = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            compare(n, l, m, tag);
            if (poke_at > 0 && i == poke_at) poke = 1'b1;
            @(negedge clk);
            if (poke) begin
                poke = 1'b0;
                n = 0;
                check(!irq_o && !nmi_o && cnt_value == 24'(exp_count(0, l, m)),
                      {tag, " R8 poke restart"}, cnt_value, exp_count(0, l, m));
            end else begin
                n++;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", chk, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cnt_value == 0, "R1 count", cnt_value, 0);
        check(!irq_o && !nmi_o && !rst_req_o, "R1 outputs",
              {irq_o, nmi_o, rst_req_o}, 0);

        // R9 disabled after reset: poke does nothing visible
        @(negedge clk); poke = 1'b1;
        @(negedge clk); poke = 1'b0;
        repeat (600) @(negedge clk);
        check(cnt_value == 0 && !irq_o, "R9 poke while off", cnt_value, 0);

        // directed escalation, minimal period
        run_scn(0, 3, 4 * D + 20, 0, "full");
        run_scn(0, 1, 4 * D + 20, 0, "irq-only");
        run_scn(0, 2, 4 * D + 20, 0, "irq-nmi");
        run_scn(5, 0, 3 * D, 100, "R9 off len5");
        run_scn(3, 3, 3 * D + 5, 0, "countdown");
        run_scn(0, 3, 4 * D + 20, 2 * D + 7, "poke-mid");
        // R4 full period of LEN=1 (256 ticks)
        run_scn(1, 1, 256 * D + 8, 0, "len1");

        // random mix
        for (int k = 0; k < 20; k++) begin
            int l, m, pa;
            l  = ($urandom % 4 == 0) ? int'($urandom % 300) + 1 : 0;
            m  = int'($urandom % 4);
            pa = ($urandom % 2 == 0) ? 0 : int'($urandom % (3 * D)) + 1;
            run_scn(l, m, 4 * D + 10, pa, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", chk, fails);
        $finish;
    end

endmodule